// File: doc/BRIEF.md
# Node Identity Status Register

This block holds the identity of a node on a serial bus: a 10-bit bus number that software may set, and a 6-bit physical node number that the PHY side delivers once the bus has settled after a reset. Three flags sit beside the identity. One says whether the node number is currently trustworthy, one says whether this node came out of the last reset as root, and one carries the PHY's most recent verdict on cable power. Software sees everything as a single 32-bit read word.

The PHY side drives the register with single-cycle events. A bus reset pulse drops the valid and root flags. A node-number delivery pulse loads the node number, samples the root indication and marks the identity valid. A status pulse samples the cable power indication. When a bus reset and a node-number delivery land in the same cycle, the reset takes precedence. Software writes reach only the bus-number field, qualified per byte lane. A combinational qualifier, `tx_run_ok_o`, tells the asynchronous transmit engines whether they may start. It is high only when the identity is valid and the node number is not the all-ones value 63.

Top module: `nid_status_reg`

## Requirements
- R1: After reset the read word is 32'h0000_FFFF: valid, root and cable-power flags are 0, bus number (bits 15:6) is all ones, node number (bits 5:0) is 63. `tx_run_ok_o` is 0.
- R2: A `bus_reset_i` pulse clears the valid flag (bit 31) and the root flag (bit 30) in the next cycle.
- R3: A `node_load_i` pulse without a bus reset sets bit 31, loads `node_i` into bits 5:0 and loads `root_i` into bit 30 in the next cycle.
- R4: When `bus_reset_i` and `node_load_i` are both high, the bus reset wins: bit 31 and bit 30 are 0 next cycle and bits 5:0 keep their old value.
- R5: A `stat_upd_i` pulse loads `cps_i` into bit 27 in the next cycle. Bit 27 is unchanged otherwise.
- R6: A write (`wr_en_i`) updates bits 7:6 from `wr_data_i[7:6]` when `wr_be_i[0]` is set, and updates bits 15:8 from `wr_data_i[15:8]` when `wr_be_i[1]` is set. `wr_be_i[3:2]` have no effect.
- R7: Writes never change bits 31:16 or bits 5:0. Bits 29:28 and 26:16 always read 0.
- R8: `tx_run_ok_o` is 1 exactly when bit 31 is 1 and bits 5:0 are not 63.
- R9: A bus reset leaves the bus number (bits 15:6) unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_reset_i | input | 1 | Bus reset detected (single-cycle pulse) |
| node_load_i | input | 1 | New node number delivered (single-cycle pulse) |
| node_i | input | 6 | Node number accompanying `node_load_i` |
| root_i | input | 1 | Root indication, sampled with `node_load_i` |
| stat_upd_i | input | 1 | PHY status report (single-cycle pulse) |
| cps_i | input | 1 | Cable power OK indication, sampled with `stat_upd_i` |
| wr_en_i | input | 1 | Software write strobe |
| wr_be_i | input | 4 | Byte-lane enables for the write |
| wr_data_i | input | 32 | Software write data |
| rd_data_o | output | 32 | Register read word |
| tx_run_ok_o | output | 1 | Asynchronous transmit may start |

## Verification
The bench loads all 64 node numbers and checks the transmit qualifier at each one. It catches a design that compares against the wrong sentinel, or that ignores the valid flag and so lets transmit run at node 63 or while the identity is stale. It sweeps all 16 byte-enable combinations against complementary data patterns. A lane decoded from the wrong bit, or upper lanes that leak into the node field or the flags, would show up as a mismatched read word. It also drives a bus reset in the same cycle as a node delivery. A design that gave the delivery priority would show the valid bit set and a new node number. Bus resets with a programmed bus number confirm that the software field survives the reset.

// File: rtl/nid_pkg.sv
package nid_pkg;

   localparam int unsigned WORD_W    = 32;
   localparam int unsigned VALID_POS = 31;
   localparam int unsigned ROOT_POS  = 30;
   localparam int unsigned CPWR_POS  = 27;
   localparam int unsigned BUS_LSB   = 6;
   localparam int unsigned LANE_W    = 8;

   typedef struct packed {
      logic valid;
      logic root;
      logic cpwr;
   } phy_flags_t;

endpackage

// File: rtl/nid_phy_track.sv
module nid_phy_track
   import nid_pkg::*;
#(
   parameter int unsigned NODE_W = 6
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_reset_i,
   input  logic              node_load_i,
   input  logic [NODE_W-1:0] node_i,
   input  logic              root_i,
   input  logic              stat_upd_i,
   input  logic              cps_i,
   output phy_flags_t        flags_o,
   output logic [NODE_W-1:0] node_o
);

   localparam logic [NODE_W-1:0] NODE_RST = '1;

   phy_flags_t        flags_q;
   logic [NODE_W-1:0] node_q;
   logic              accept_node;

   // A bus reset in the same cycle masks the node delivery
   assign accept_node = node_load_i & ~bus_reset_i;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         flags_q <= '0;
         node_q  <= NODE_RST;
      end else begin
         if (bus_reset_i) begin
            flags_q.valid <= 1'b0;
            flags_q.root  <= 1'b0;
         end else if (accept_node) begin
            flags_q.valid <= 1'b1;
            flags_q.root  <= root_i;
         end
         if (accept_node)
            node_q <= node_i;
         if (stat_upd_i)
            flags_q.cpwr <= cps_i;
      end
   end

   assign flags_o = flags_q;
   assign node_o  = node_q;

   a_r4_reset_wins : assert property (@(posedge clk) disable iff (!rst_n)
      (bus_reset_i && node_load_i) |=> (!flags_o.valid && node_o == $past(node_o)));

   a_r5_cpwr_hold : assert property (@(posedge clk) disable iff (!rst_n)
      !stat_upd_i |=> (flags_o.cpwr == $past(flags_o.cpwr)));

endmodule

// File: rtl/nid_busnum_reg.sv
module nid_busnum_reg
   import nid_pkg::*;
#(
   parameter int unsigned BUS_W   = 10,
   parameter int unsigned FIELD_LSB = 6,
   parameter bit          BYTE_EN = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en_i,
   input  logic [3:0]        wr_be_i,
   input  logic [WORD_W-1:0] wr_data_i,
   output logic [BUS_W-1:0]  bus_o
);

   localparam logic [BUS_W-1:0] BUS_RST = '1;

   logic [BUS_W-1:0] bit_en;
   logic [BUS_W-1:0] bus_q;

   generate
      if (BYTE_EN) begin : g_lane
         for (genvar i = 0; i < BUS_W; i++) begin : g_bit
            localparam int unsigned LANE = (FIELD_LSB + i) / LANE_W;
            assign bit_en[i] = wr_be_i[LANE];
         end
      end else begin : g_word
         assign bit_en = '1;
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         bus_q <= BUS_RST;
      end else if (wr_en_i) begin
         for (int i = 0; i < BUS_W; i++)
            if (bit_en[i])
               bus_q[i] <= wr_data_i[FIELD_LSB + i];
      end
   end

   assign bus_o = bus_q;

   a_r9_no_write_hold : assert property (@(posedge clk) disable iff (!rst_n)
      !wr_en_i |=> (bus_o == $past(bus_o)));

endmodule

// File: rtl/nid_pack.sv
module nid_pack
   import nid_pkg::*;
#(
   parameter int unsigned NODE_W = 6,
   parameter int unsigned BUS_W  = 10
) (
   input  phy_flags_t        flags_i,
   input  logic [NODE_W-1:0] node_i,
   input  logic [BUS_W-1:0]  bus_i,
   output logic [WORD_W-1:0] word_o,
   output logic              tx_ok_o
);

   localparam logic [NODE_W-1:0] NODE_BAD = '1;

   always_comb begin
      word_o                              = '0;
      word_o[VALID_POS]                   = flags_i.valid;
      word_o[ROOT_POS]                    = flags_i.root;
      word_o[CPWR_POS]                    = flags_i.cpwr;
      word_o[BUS_LSB +: BUS_W]            = bus_i;
      word_o[NODE_W-1:0]                  = node_i;
   end

   assign tx_ok_o = flags_i.valid && (node_i != NODE_BAD);

endmodule

// File: rtl/nid_status_reg.sv
module nid_status_reg
   import nid_pkg::*;
#(
   parameter int unsigned NODE_W  = 6,
   parameter int unsigned BUS_W   = 10,
   parameter bit          BYTE_EN = 1'b1
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        bus_reset_i,
   input  logic        node_load_i,
   input  logic [5:0]  node_i,
   input  logic        root_i,
   input  logic        stat_upd_i,
   input  logic        cps_i,
   input  logic        wr_en_i,
   input  logic [3:0]  wr_be_i,
   input  logic [31:0] wr_data_i,
   output logic [31:0] rd_data_o,
   output logic        tx_run_ok_o
);

   localparam int unsigned ID_W = NODE_W + BUS_W;

   generate
      if (ID_W != 16) begin : g_bad_id
         $error("node and bus fields must fill 16 bits");
      end
      if (NODE_W != BUS_LSB) begin : g_bad_node
         $error("node field width must match bus field offset");
      end
   endgenerate

   phy_flags_t        flags;
   logic [NODE_W-1:0] node;
   logic [BUS_W-1:0]  bus;

   nid_phy_track #(.NODE_W(NODE_W)) u_track (
      .clk        (clk),
      .rst_n      (rst_n),
      .bus_reset_i(bus_reset_i),
      .node_load_i(node_load_i),
      .node_i     (node_i[NODE_W-1:0]),
      .root_i     (root_i),
      .stat_upd_i (stat_upd_i),
      .cps_i      (cps_i),
      .flags_o    (flags),
      .node_o     (node)
   );

   nid_busnum_reg #(.BUS_W(BUS_W), .FIELD_LSB(BUS_LSB), .BYTE_EN(BYTE_EN)) u_bus (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en_i  (wr_en_i),
      .wr_be_i  (wr_be_i),
      .wr_data_i(wr_data_i),
      .bus_o    (bus)
   );

   nid_pack #(.NODE_W(NODE_W), .BUS_W(BUS_W)) u_pack (
      .flags_i(flags),
      .node_i (node),
      .bus_i  (bus),
      .word_o (rd_data_o),
      .tx_ok_o(tx_run_ok_o)
   );

   a_r2_reset_clears : assert property (@(posedge clk) disable iff (!rst_n)
      bus_reset_i |=> (!rd_data_o[31] && !rd_data_o[30]));

   a_r3_node_load : assert property (@(posedge clk) disable iff (!rst_n)
      (node_load_i && !bus_reset_i) |=> (rd_data_o[31] && rd_data_o[5:0] == $past(node_i)
                                         && rd_data_o[30] == $past(root_i)));

   a_r5_cpwr_load : assert property (@(posedge clk) disable iff (!rst_n)
      stat_upd_i |=> (rd_data_o[27] == $past(cps_i)));

   a_r7_write_no_node : assert property (@(posedge clk) disable iff (!rst_n)
      !node_load_i |=> (rd_data_o[5:0] == $past(rd_data_o[5:0])));

   a_r7_reserved_zero : assert property (@(posedge clk) disable iff (!rst_n)
      (rd_data_o[29:28] == 2'b00 && rd_data_o[26:16] == 11'd0));

   a_r8_tx_gate : assert property (@(posedge clk) disable iff (!rst_n)
      tx_run_ok_o |-> (rd_data_o[31] && rd_data_o[5:0] != 6'd63));

   a_r9_bus_survives : assert property (@(posedge clk) disable iff (!rst_n)
      (bus_reset_i && !wr_en_i) |=> (rd_data_o[15:6] == $past(rd_data_o[15:6])));

endmodule

// File: tb/sim_nid_status_reg.sv
module sim_nid_status_reg;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_reset_i = 1'b0, node_load_i = 1'b0, root_i = 1'b0;
   logic        stat_upd_i = 1'b0, cps_i = 1'b0, wr_en_i = 1'b0;
   logic [5:0]  node_i = '0;
   logic [3:0]  wr_be_i = '0;
   logic [31:0] wr_data_i = '0;
   logic [31:0] rd_data_o;
   logic        tx_run_ok_o;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   // bench model
   logic       m_valid, m_root, m_cps;
   logic [9:0] m_bus;
   logic [5:0] m_node;

   always #2 clk = ~clk;   // 250 MHz

   nid_status_reg u0 (
      .clk(clk), .rst_n(rst_n), .bus_reset_i(bus_reset_i), .node_load_i(node_load_i),
      .node_i(node_i), .root_i(root_i), .stat_upd_i(stat_upd_i), .cps_i(cps_i),
      .wr_en_i(wr_en_i), .wr_be_i(wr_be_i), .wr_data_i(wr_data_i),
      .rd_data_o(rd_data_o), .tx_run_ok_o(tx_run_ok_o)
   );

   function automatic logic [31:0] exp_word();
      return {m_valid, m_root, 2'b00, m_cps, 11'd0, m_bus, m_node};
   endfunction

   task automatic check_word(input string req);
      checks++;
      if (rd_data_o !== exp_word()) begin
         fails++;
         $display("FAIL %s: rd_data_o=%h expected %h", req, rd_data_o, exp_word());
      end
   endtask

   task automatic check_tx(input string req);
      logic e;
      e = m_valid && (m_node != 6'd63);
      checks++;
      if (tx_run_ok_o !== e) begin
         fails++;
         $display("FAIL %s: tx_run_ok_o=%b expected %b", req, tx_run_ok_o, e);
      end
   endtask

   // drive one cycle of stimulus on a negedge, return on the next negedge
   task automatic step();
      @(negedge clk);
      bus_reset_i = 0; node_load_i = 0; stat_upd_i = 0; wr_en_i = 0;
   endtask

   task automatic load_node(input logic [5:0] n, input logic r);
      node_load_i = 1; node_i = n; root_i = r;
      step();
      m_valid = 1; m_node = n; m_root = r;
   endtask

   task automatic bus_reset();
      bus_reset_i = 1;
      step();
      m_valid = 0; m_root = 0;
   endtask

   task automatic sw_write(input logic [3:0] be, input logic [31:0] d);
      wr_en_i = 1; wr_be_i = be; wr_data_i = d;
      step();
      for (int p = 6; p < 16; p++)
         if (be[p/8]) m_bus[p-6] = d[p];
   endtask

   initial begin
      #(200000 * 4);
      if (!done) begin
         fails++;
         $display("FAIL watchdog: run did not complete, expected completion");
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end

   initial begin
      m_valid = 0; m_root = 0; m_cps = 0; m_bus = '1; m_node = 6'd63;
      repeat (3) @(negedge clk);
      rst_n = 1;
      @(negedge clk);
      check_word("R1 reset word");
      check_tx("R1 reset tx");

      // R3/R8: sweep all node numbers with both root values
      for (int n = 0; n < 64; n++) begin
         load_node(6'(n), n[0]);
         check_word("R3 node load");
         check_tx("R8 tx qualifier");
      end

      // R2: bus reset after a good node
      load_node(6'd5, 1'b1);
      bus_reset();
      check_word("R2 bus reset clears flags");
      check_tx("R8 tx blocked after reset");

      // R4: simultaneous reset and delivery
      load_node(6'd9, 1'b1);
      bus_reset_i = 1; node_load_i = 1; node_i = 6'd20; root_i = 1;
      step();
      m_valid = 0; m_root = 0;
      check_word("R4 reset wins");
      check_tx("R4 tx after collision");

      // R5: cable power status
      for (int k = 0; k < 4; k++) begin
         stat_upd_i = 1; cps_i = k[0] ^ k[1];
         step();
         m_cps = k[0] ^ k[1];
         check_word("R5 cable power load");
         cps_i = ~cps_i;
         step();
         check_word("R5 cable power hold");
      end

      // R6/R7: byte-enable sweep with complementary patterns
      load_node(6'd17, 1'b0);
      for (int be = 0; be < 16; be++) begin
         sw_write(4'(be), 32'hFFFF_FF00 ^ {be[3:0], 28'h5A5_A5A5});
         check_word("R6 R7 write lanes");
         sw_write(4'(be), ~(32'hFFFF_FF00 ^ {be[3:0], 28'h5A5_A5A5}));
         check_word("R6 R7 write lanes inverted");
         check_tx("R7 tx unchanged by write");
      end

      // R9: bus number survives bus reset
      sw_write(4'b0011, 32'h0000_A5C0);
      bus_reset();
      check_word("R9 bus number after reset");
      sw_write(4'b0000, 32'hFFFF_FFFF);
      check_word("R6 no lanes enabled");

      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

endmodule